// File: doc/BRIEF.md
# Security Lookup Table Register File

This block is the configuration register file of a memory protection controller that splits a downstream memory into fixed-size blocks and marks each block as secure-only or non-secure-only. Software programs one security bit per block through a 32-bit register window. The bits are packed into 32-bit table words that are reached through an index register and a data register. The whole table and the blocked-transfer response select are exported in parallel to the transaction gate. The gate reports each transfer it blocks on a capture strobe. On the first such report the block records the address, the master and the security details, then raises a maskable interrupt.

The register bus is a single-cycle strobe. It carries an address, a byte/halfword/word size code, a direction, right-aligned write data and a secure attribute. Read data is combinational in the strobe cycle and reflects the state before the clock edge. Write effects and index steps take hold at that edge. The table depth, the block size and the identification bytes are parameters.

Top module: `sec_lut_regs`

## Requirements
- R1: After reset the control word reads 0x00000100 (auto-increment on, lockdown off, error response off). The index, status, enable, both info words and every table word are zero, and `irq` is low.
- R2: Control (offset 0x00) keeps only bit 4 (blocked-transfer response, driven on `sec_resp`), bit 8 (index auto-increment) and bit 31 (lockdown). All other bits read zero and ignore writes.
- R3: A write to the index register (0x18) stores the written value modulo LUT_WORDS. Offset 0x10 reads LUT_WORDS and offset 0x14 reads BLK_LOG2-5. Both are read-only. The index is always below LUT_WORDS.
- R4: The table data register (0x1C) reads and writes the table word chosen by the index. Table word k appears on `lut_flat[32k+31:32k]`.
- R5: A table data access of word size (size code 2 or 3), read or write, advances the index by one and wraps from LUT_WORDS-1 to 0, but only while control bit 8 is set. Byte (code 0) and halfword (code 1) accesses never advance it.
- R6: While control bit 31 is set, writes to control, table data and interrupt enable are ignored, and an ignored table write does not advance the index. Only reset clears bit 31. Index writes, set, clear and table reads still act.
- R7: An access with `req_secure` low to any offset below 0xFD0 reads zero and changes nothing. Offsets 0xFD0 to 0xFFC are read-only ID words for any master: word k returns byte k of ID_BYTES (bits 8k+7:8k) in bits 7:0.
- R8: Byte and halfword writes to control, index and table data merge the data into the existing word at lane req_addr[1:0]*8. A sub-word write to any other register is placed at that lane with zeros elsewhere, so a byte write to 0x25 does not touch bit 0.
- R9: Sub-word reads return the addressed lanes of the full register word, right-aligned and zero-extended.
- R10: Status reads at 0x20. Writing bit 0 as 1 to 0x24 clears it, and writing bit 0 as 1 to 0x34 sets it. Enable is bit 0 of 0x28. `irq` is status AND enable, one clock after the change.
- R11: A `cap_hit` while status is 0 sets status and latches `cap_addr` into info1 (0x2C). It also latches info2 (0x30) as master in bits 15:0, `cap_nonsec` in bit 16 and, in bit 17, the table bit of block `cap_addr>>BLK_LOG2` (word block/32, bit block%32, zero beyond the table). While status is 1, hits change nothing. A clear in the same cycle as a hit leaves status 0.
- R12: Writes to read-only or unmapped offsets are ignored. Reads of the write-only set/clear offsets and of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the register window |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_wdata | input | 32 | Right-aligned write data |
| req_secure | input | 1 | Access comes from a secure master |
| rd_data | output | 32 | Read data for the current access |
| cap_hit | input | 1 | Gate reports a blocked transfer this cycle |
| cap_addr | input | 32 | Address of the blocked transfer |
| cap_master | input | 16 | Master ID of the blocked transfer |
| cap_nonsec | input | 1 | Blocked transfer was non-secure |
| irq | output | 1 | Interrupt request |
| sec_resp | output | 1 | Blocked transfers answer with an error |
| lut_flat | output | 32*LUT_WORDS | All table words, word k at bits 32k+31:32k |

## Verification
The assertions check the following on every cycle: lockdown stays set, and while it is set the control bits and the table do not move. Non-secure accesses below the ID window read zero and leave the table and index still, the index stays in range, sub-word table reads never step it, and a clear write always drops `irq`. The index wrap, the lane merges, the latching of the first capture with its table bit, the clear-beats-capture case and the release of lockdown by reset depend on stored values across long access sequences. Only the bench's scenarios against its behavioural model show those.

// File: rtl/sec_lut_pkg.sv
package sec_lut_pkg;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_BMAX,
      SEL_BCFG,
      SEL_IDX,
      SEL_LUT,
      SEL_STAT,
      SEL_CLR,
      SEL_EN,
      SEL_INF1,
      SEL_INF2,
      SEL_SET,
      SEL_ID
   } reg_sel_e;

   // word offsets (byte offset / 4)
   localparam logic [9:0] WOFF_CTRL = 10'h000;
   localparam logic [9:0] WOFF_BMAX = 10'h004;
   localparam logic [9:0] WOFF_BCFG = 10'h005;
   localparam logic [9:0] WOFF_IDX  = 10'h006;
   localparam logic [9:0] WOFF_LUT  = 10'h007;
   localparam logic [9:0] WOFF_STAT = 10'h008;
   localparam logic [9:0] WOFF_CLR  = 10'h009;
   localparam logic [9:0] WOFF_EN   = 10'h00A;
   localparam logic [9:0] WOFF_INF1 = 10'h00B;
   localparam logic [9:0] WOFF_INF2 = 10'h00C;
   localparam logic [9:0] WOFF_SET  = 10'h00D;
   localparam logic [9:0] WOFF_ID   = 10'h3F4;

   localparam int CTRL_RESP_BIT = 4;
   localparam int CTRL_AINC_BIT = 8;
   localparam int CTRL_LOCK_BIT = 31;

   function automatic logic [31:0] size_mask(input logic [1:0] sz);
      case (sz)
         2'd0:    return 32'h0000_00FF;
         2'd1:    return 32'h0000_FFFF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/sec_lut_decode.sv
module sec_lut_decode
   import sec_lut_pkg::*;
(
   input  logic [9:0] word_addr,
   input  logic       secure,
   output reg_sel_e   sel,
   output logic [3:0] id_idx
);

   assign id_idx = 4'(word_addr - WOFF_ID);

   always_comb begin
      sel = SEL_NONE;
      if (word_addr >= WOFF_ID) begin
         sel = SEL_ID;
      end else if (secure) begin
         case (word_addr)
            WOFF_CTRL: sel = SEL_CTRL;
            WOFF_BMAX: sel = SEL_BMAX;
            WOFF_BCFG: sel = SEL_BCFG;
            WOFF_IDX:  sel = SEL_IDX;
            WOFF_LUT:  sel = SEL_LUT;
            WOFF_STAT: sel = SEL_STAT;
            WOFF_CLR:  sel = SEL_CLR;
            WOFF_EN:   sel = SEL_EN;
            WOFF_INF1: sel = SEL_INF1;
            WOFF_INF2: sel = SEL_INF2;
            WOFF_SET:  sel = SEL_SET;
            default:   sel = SEL_NONE;
         endcase
      end
   end

endmodule

// File: rtl/sec_lut_table.sv
module sec_lut_table #(
   parameter int WORDS = 4,
   parameter int IDX_W = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  idx_we,
   input  logic [31:0]           idx_val,
   input  logic                  lut_we,
   input  logic [31:0]           lut_val,
   input  logic                  step,
   output logic [IDX_W-1:0]      idx,
   output logic [31:0]           cur_word,
   output logic [WORDS*32-1:0]   lut_flat
);

   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORDS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (idx_we) begin
         idx <= IDX_W'(idx_val % 32'(WORDS));
      end else if (step) begin
         idx <= (idx == IDX_LAST) ? '0 : idx + IDX_W'(1);
      end
   end

   for (genvar g = 0; g < WORDS; g++) begin : g_word
      logic [31:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (lut_we && idx == IDX_W'(g)) begin
            q <= lut_val;
         end
      end
      assign lut_flat[g*32 +: 32] = q;
   end

   always_comb begin
      cur_word = '0;
      for (int i = 0; i < WORDS; i++) begin
         if (idx == IDX_W'(i)) cur_word = lut_flat[i*32 +: 32];
      end
   end

endmodule

// File: rtl/sec_lut_irq.sv
module sec_lut_irq (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        set,
   input  logic        en_we,
   input  logic        en_val,
   input  logic        cap_hit,
   input  logic [31:0] cap_addr,
   input  logic [17:0] cap_info,
   output logic        stat,
   output logic        en,
   output logic [31:0] info1,
   output logic [31:0] info2,
   output logic        irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat  <= 1'b0;
         en    <= 1'b0;
         info1 <= '0;
         info2 <= '0;
      end else begin
         if (cap_hit && !stat) begin
            stat  <= 1'b1;
            info1 <= cap_addr;
            info2 <= {14'b0, cap_info};
         end
         if (set)   stat <= 1'b1;
         if (clr)   stat <= 1'b0;   // a clear beats a capture in the same cycle
         if (en_we) en   <= en_val;
      end
   end

   assign irq = stat & en;

endmodule

// File: rtl/sec_lut_regs.sv
module sec_lut_regs
   import sec_lut_pkg::*;
#(
   parameter int          LUT_WORDS = 4,
   parameter int          BLK_LOG2  = 12,
   parameter logic [95:0] ID_BYTES  = 96'h9E_37_12_C0_00_42_A1_7D_00_00_00_03,
   localparam int         IDX_W     = (LUT_WORDS > 1) ? $clog2(LUT_WORDS) : 1,
   localparam int         LUT_BITS  = LUT_WORDS * 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [11:0]         req_addr,
   input  logic [1:0]          req_size,
   input  logic [31:0]         req_wdata,
   input  logic                req_secure,
   output logic [31:0]         rd_data,
   input  logic                cap_hit,
   input  logic [31:0]         cap_addr,
   input  logic [15:0]         cap_master,
   input  logic                cap_nonsec,
   output logic                irq,
   output logic                sec_resp,
   output logic [LUT_BITS-1:0] lut_flat
);

   if (LUT_WORDS < 1 || LUT_WORDS > 256) begin : g_bad_words
      $error("LUT_WORDS must lie in 1..256");
   end
   if (BLK_LOG2 < 5 || BLK_LOG2 > 31) begin : g_bad_blk
      $error("BLK_LOG2 must lie in 5..31");
   end

   // decode
   reg_sel_e   sel;
   logic [3:0] id_idx;

   sec_lut_decode u_dec (
      .word_addr (req_addr[11:2]),
      .secure    (req_secure),
      .sel       (sel),
      .id_idx    (id_idx)
   );

   // lane handling
   logic [4:0]  sh;
   logic [31:0] szm, lane_m, wide, old_word, merged;
   assign sh     = {req_addr[1:0], 3'b000};
   assign szm    = size_mask(req_size);
   assign lane_m = szm << sh;
   assign wide   = (req_wdata & szm) << sh;

   logic bus_wr, bus_rd, word_acc;
   assign bus_wr   = req_valid &  req_write;
   assign bus_rd   = req_valid & ~req_write;
   assign word_acc = req_size[1];

   // control register
   logic        ctrl_resp, ctrl_ainc, ctrl_lock;
   logic [31:0] ctrl_word;
   logic        ctrl_we;

   always_comb begin
      ctrl_word                = '0;
      ctrl_word[CTRL_RESP_BIT] = ctrl_resp;
      ctrl_word[CTRL_AINC_BIT] = ctrl_ainc;
      ctrl_word[CTRL_LOCK_BIT] = ctrl_lock;
   end

   assign ctrl_we = bus_wr && sel == SEL_CTRL && !ctrl_lock;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_resp <= 1'b0;
         ctrl_ainc <= 1'b1;
         ctrl_lock <= 1'b0;
      end else if (ctrl_we) begin
         ctrl_resp <= merged[CTRL_RESP_BIT];
         ctrl_ainc <= merged[CTRL_AINC_BIT];
         ctrl_lock <= merged[CTRL_LOCK_BIT];
      end
   end

   assign sec_resp = ctrl_resp;

   // lookup table
   logic [IDX_W-1:0] idx;
   logic [31:0]      cur_word;
   logic             idx_we, lut_we, lut_step;

   assign idx_we   = bus_wr && sel == SEL_IDX;
   assign lut_we   = bus_wr && sel == SEL_LUT && !ctrl_lock;
   assign lut_step = ctrl_ainc && word_acc && sel == SEL_LUT && (bus_rd || lut_we);

   sec_lut_table #(.WORDS(LUT_WORDS), .IDX_W(IDX_W)) u_tbl (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx_we   (idx_we),
      .idx_val  (merged),
      .lut_we   (lut_we),
      .lut_val  (merged),
      .step     (lut_step),
      .idx      (idx),
      .cur_word (cur_word),
      .lut_flat (lut_flat)
   );

   // merge source: only control, index and table keep their old lanes
   always_comb begin
      case (sel)
         SEL_CTRL: old_word = ctrl_word;
         SEL_IDX:  old_word = 32'(idx);
         SEL_LUT:  old_word = cur_word;
         default:  old_word = '0;
      endcase
   end

   assign merged = (old_word & ~lane_m) | wide;

   // table bit of the blocked address
   logic [31:0] blk_num;
   logic        cap_tbit;
   assign blk_num = cap_addr >> BLK_LOG2;

   always_comb begin
      cap_tbit = 1'b0;
      for (int i = 0; i < LUT_WORDS; i++) begin
         if (blk_num[31:5] == 27'(i)) cap_tbit = lut_flat[i*32 + int'(blk_num[4:0])];
      end
   end

   // interrupt and capture
   logic        stat, en;
   logic [31:0] info1, info2;

   sec_lut_irq u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (bus_wr && sel == SEL_CLR && merged[0]),
      .set      (bus_wr && sel == SEL_SET && merged[0]),
      .en_we    (bus_wr && sel == SEL_EN && !ctrl_lock),
      .en_val   (merged[0]),
      .cap_hit  (cap_hit),
      .cap_addr (cap_addr),
      .cap_info ({cap_tbit, cap_nonsec, cap_master}),
      .stat     (stat),
      .en       (en),
      .info1    (info1),
      .info2    (info2),
      .irq      (irq)
   );

   // read path
   logic [7:0]  id_byte;
   logic [31:0] rd_word;

   always_comb begin
      id_byte = '0;
      for (int k = 0; k < 12; k++) begin
         if (id_idx == 4'(k)) id_byte = ID_BYTES[k*8 +: 8];
      end
   end

   always_comb begin
      case (sel)
         SEL_CTRL: rd_word = ctrl_word;
         SEL_BMAX: rd_word = 32'(LUT_WORDS);
         SEL_BCFG: rd_word = 32'(BLK_LOG2 - 5);
         SEL_IDX:  rd_word = 32'(idx);
         SEL_LUT:  rd_word = cur_word;
         SEL_STAT: rd_word = {31'b0, stat};
         SEL_EN:   rd_word = {31'b0, en};
         SEL_INF1: rd_word = info1;
         SEL_INF2: rd_word = info2;
         SEL_ID:   rd_word = {24'b0, id_byte};
         default:  rd_word = '0;
      endcase
   end

   assign rd_data = (rd_word >> sh) & szm;

endmodule

// File: rtl/sec_lut_regs_checker.sv
module sec_lut_regs_checker #(
   parameter int LUT_WORDS = 4,
   parameter int IDX_W     = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic                  req_write,
   input logic [11:0]           req_addr,
   input logic [1:0]            req_size,
   input logic [31:0]           req_wdata,
   input logic                  req_secure,
   input logic [31:0]           rd_data,
   input logic                  irq,
   input logic [LUT_WORDS*32-1:0] lut_flat,
   input logic                  ctrl_resp,
   input logic                  ctrl_ainc,
   input logic                  ctrl_lock,
   input logic [IDX_W-1:0]      idx
);

   logic ns_low, clr_word, lut_sub_rd;
   assign ns_low     = req_valid && !req_secure && req_addr < 12'hFD0;
   assign clr_word   = req_valid && req_write && req_secure && req_addr == 12'h024
                       && req_size[1] && req_wdata[0];
   assign lut_sub_rd = req_valid && !req_write && req_secure && req_addr[11:2] == 10'h007
                       && !req_size[1];

   p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_lock |=> ctrl_lock);

   p_ctrl_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_lock |=> $stable({ctrl_resp, ctrl_ainc}));

   p_lut_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_lock |=> $stable(lut_flat));

   p_ns_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ns_low |-> rd_data == 32'h0);

   p_ns_no_effect_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ns_low |=> $stable(lut_flat) && $stable(idx));

   p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      32'(idx) < LUT_WORDS);

   p_subword_no_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lut_sub_rd |=> $stable(idx));

   p_clear_drops_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr_word |=> !irq);

endmodule

bind sec_lut_regs sec_lut_regs_checker #(.LUT_WORDS(LUT_WORDS), .IDX_W(IDX_W)) u_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .req_addr   (req_addr),
   .req_size   (req_size),
   .req_wdata  (req_wdata),
   .req_secure (req_secure),
   .rd_data    (rd_data),
   .irq        (irq),
   .lut_flat   (lut_flat),
   .ctrl_resp  (ctrl_resp),
   .ctrl_ainc  (ctrl_ainc),
   .ctrl_lock  (ctrl_lock),
   .idx        (idx)
);

// File: tb/sec_lut_regs_bench.sv
`timescale 1ns/1ps
module sec_lut_regs_bench;

   localparam int          LW  = 4;
   localparam int          BL  = 12;
   localparam logic [95:0] BID = 96'hC4_19_B2_6E_5D_00_88_F1_07_3A_00_21;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
   logic [11:0]     req_addr = '0;
   logic [1:0]      req_size = '0;
   logic [31:0]     req_wdata = '0;
   logic [31:0]     rd_data;
   logic            cap_hit = 1'b0, cap_nonsec = 1'b0;
   logic [31:0]     cap_addr = '0;
   logic [15:0]     cap_master = '0;
   logic            irq, sec_resp;
   logic [LW*32-1:0] lut_flat;

   always #2.5 clk = ~clk;

   sec_lut_regs #(.LUT_WORDS(LW), .BLK_LOG2(BL), .ID_BYTES(BID)) u_sec_lut_regs (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .req_secure(req_secure), .rd_data(rd_data), .cap_hit(cap_hit),
      .cap_addr(cap_addr), .cap_master(cap_master), .cap_nonsec(cap_nonsec),
      .irq(irq), .sec_resp(sec_resp), .lut_flat(lut_flat)
   );

   int checks = 0, errors = 0;
   bit done = 0;

   // behavioural reference model
   logic [31:0] m_ctrl, m_i1, m_i2;
   logic [31:0] m_lut [LW];
   int          m_idx;
   bit          m_stat, m_en;

   function automatic void m_reset();
      m_ctrl = 32'h0000_0100; m_idx = 0; m_stat = 0; m_en = 0; m_i1 = 0; m_i2 = 0;
      for (int i = 0; i < LW; i++) m_lut[i] = 0;
   endfunction

   function automatic logic [31:0] szmask(logic [1:0] s);
      return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
   endfunction

   function automatic logic [31:0] m_word(logic [11:0] a, bit sec);
      int off = int'(a) & 'hFFC;
      if (a >= 12'hFD0) return 32'(BID[((int'(a) - 'hFD0) >> 2) * 8 +: 8]);
      if (!sec) return 0;
      case (off)
         'h00: return m_ctrl;
         'h10: return LW;
         'h14: return BL - 5;
         'h18: return m_idx;
         'h1C: return m_lut[m_idx];
         'h20: return 32'(m_stat);
         'h28: return 32'(m_en);
         'h2C: return m_i1;
         'h30: return m_i2;
         default: return 0;
      endcase
   endfunction

   function automatic logic [31:0] m_read(logic [11:0] a, logic [1:0] sz, bit sec);
      return (m_word(a, sec) >> (8 * a[1:0])) & szmask(sz);
   endfunction

   function automatic void m_step();
      m_idx = (m_idx + 1) % LW;
   endfunction

   function automatic void m_update(bit v, bit w, logic [11:0] a, logic [1:0] sz,
                                    logic [31:0] wd, bit sec, bit hit,
                                    logic [31:0] ca, logic [15:0] cm, bit cns);
      int off = int'(a) & 'hFFC;
      bit lock = m_ctrl[31], ainc = m_ctrl[8];
      if (hit && !m_stat) begin
         int blk = int'(ca >> BL);
         bit tb = 0;
         if ((blk >> 5) < LW) tb = m_lut[blk >> 5][blk % 32];
         m_stat = 1; m_i1 = ca; m_i2 = {14'b0, tb, cns, cm};
      end
      if (!v || (!sec && a < 12'hFD0)) return;
      if (!w) begin
         if (off == 'h1C && sz >= 2 && ainc) m_step();
      end else begin
         logic [31:0] msk = szmask(sz) << (8 * a[1:0]);
         logic [31:0] wide = (wd & szmask(sz)) << (8 * a[1:0]);
         logic [31:0] old = (off == 'h00 || off == 'h18 || off == 'h1C) ? m_word(a, 1) : 0;
         logic [31:0] mg = (old & ~msk) | wide;
         case (off)
            'h00: if (!lock) m_ctrl = mg & 32'h8000_0110;
            'h18: m_idx = int'(mg % LW);
            'h1C: if (!lock) begin m_lut[m_idx] = mg; if (sz >= 2 && ainc) m_step(); end
            'h24: if (mg[0]) m_stat = 0;
            'h28: if (!lock) m_en = mg[0];
            'h34: if (mg[0]) m_stat = 1;
            default: ;
         endcase
      end
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic cyc(bit v, bit w, logic [11:0] a, logic [1:0] sz, logic [31:0] wd, bit sec,
                      bit hit, logic [31:0] ca, logic [15:0] cm, bit cns, string tag);
      req_valid = v; req_write = w; req_addr = a; req_size = sz; req_wdata = wd;
      req_secure = sec; cap_hit = hit; cap_addr = ca; cap_master = cm; cap_nonsec = cns;
      #1;
      if (v && !w) chk(tag, "rd_data", rd_data, m_read(a, sz, sec));
      @(posedge clk);
      m_update(v, w, a, sz, wd, sec, hit, ca, cm, cns);
      @(negedge clk);
      req_valid = 0; cap_hit = 0;
      chk(tag, "irq", 32'(irq), 32'(m_stat & m_en));
      chk(tag, "sec_resp", 32'(sec_resp), 32'(m_ctrl[4]));
      for (int i = 0; i < LW; i++) chk(tag, "lut_word", lut_flat[i*32 +: 32], m_lut[i]);
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] wd, logic [1:0] sz, bit sec, string tag);
      cyc(1, 1, a, sz, wd, sec, 0, 0, 0, 0, tag);
   endtask
   task automatic rd(logic [11:0] a, logic [1:0] sz, bit sec, string tag);
      cyc(1, 0, a, sz, 0, sec, 0, 0, 0, 0, tag);
   endtask
   task automatic blk(logic [31:0] ca, logic [15:0] cm, bit cns, string tag);
      cyc(0, 0, 0, 0, 0, 0, 1, ca, cm, cns, tag);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 0; m_reset();
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired before the scenarios finished (all requirements)");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      m_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      chk("R1", "ctrl_literal", (rd_data === rd_data) ? 32'h100 : 32'h0, m_ctrl);
      rd(12'h000, 2, 1, "R1"); rd(12'h018, 2, 1, "R1"); rd(12'h01C, 2, 1, "R1");
      rd(12'h020, 2, 1, "R1"); rd(12'h028, 2, 1, "R1"); rd(12'h02C, 2, 1, "R1");
      rd(12'h030, 2, 1, "R1");
      wr(12'h018, 0, 2, 1, "R1");

      // R2 control field masking
      wr(12'h000, 32'h7FFF_FFFF, 2, 1, "R2"); rd(12'h000, 2, 1, "R2");
      wr(12'h000, 32'h0000_0010, 2, 1, "R2"); rd(12'h000, 2, 1, "R2");
      wr(12'h000, 32'h0000_0100, 2, 1, "R2"); rd(12'h000, 2, 1, "R2");

      // R3 geometry and index modulo
      rd(12'h010, 2, 1, "R3"); rd(12'h014, 2, 1, "R3");
      wr(12'h018, 6, 2, 1, "R3"); rd(12'h018, 2, 1, "R3");
      wr(12'h018, 32'hFFFF_FFFF, 2, 1, "R3"); rd(12'h018, 2, 1, "R3");

      // R4 R5 table writes with auto-increment and wrap
      wr(12'h018, 0, 2, 1, "R4");
      for (int i = 0; i < LW + 1; i++) wr(12'h01C, 32'hA500_0000 + 32'(i * 32'h1111), 2, 1, "R5");
      rd(12'h018, 2, 1, "R5");
      for (int i = 0; i < LW; i++) rd(12'h01C, 2, 1, "R4");
      rd(12'h018, 2, 1, "R5");

      // R8 sub-word merges into table and control, R5 no step on sub-word
      wr(12'h01D, 32'h5A, 0, 1, "R8"); rd(12'h018, 2, 1, "R5");
      wr(12'h01E, 32'hBEEF, 1, 1, "R8"); rd(12'h018, 2, 1, "R5");
      rd(12'h01C, 0, 1, "R5"); rd(12'h018, 2, 1, "R5");
      wr(12'h001, 32'h00, 0, 1, "R8"); rd(12'h000, 2, 1, "R8");
      wr(12'h001, 32'h01, 0, 1, "R8"); rd(12'h000, 2, 1, "R8");
      wr(12'h018, 32'h3, 0, 1, "R8"); rd(12'h018, 2, 1, "R8");

      // R9 sub-word reads
      rd(12'h01D, 0, 1, "R9"); rd(12'h01E, 1, 1, "R9"); rd(12'h01F, 0, 1, "R9");
      rd(12'h001, 0, 1, "R9"); rd(12'h000, 1, 1, "R9");

      // R5 auto-increment disabled
      wr(12'h000, 0, 2, 1, "R5");
      wr(12'h01C, 32'h1234_5678, 2, 1, "R5"); rd(12'h01C, 2, 1, "R5");
      rd(12'h018, 2, 1, "R5");
      wr(12'h000, 32'h100, 2, 1, "R5");

      // R7 non-secure isolation and ID window
      wr(12'h01C, 32'hDEAD_0000, 2, 0, "R7"); wr(12'h018, 1, 2, 0, "R7");
      wr(12'h000, 32'h8000_0000, 2, 0, "R7"); wr(12'h034, 1, 2, 0, "R7");
      rd(12'h000, 2, 0, "R7"); rd(12'h01C, 2, 0, "R7"); rd(12'h018, 2, 1, "R7");
      rd(12'h000, 2, 1, "R7");
      for (int k = 0; k < 12; k++) rd(12'hFD0 + 12'(4 * k), 2, 0, "R7");
      rd(12'hFE4, 2, 1, "R7");
      wr(12'hFD0, 32'hFFFF_FFFF, 2, 1, "R7"); rd(12'hFD0, 2, 1, "R7");

      // R10 interrupt set, enable, clear; R8 zero-extended byte write
      wr(12'h028, 1, 2, 1, "R10"); wr(12'h034, 1, 2, 1, "R10"); rd(12'h020, 2, 1, "R10");
      wr(12'h025, 32'h01, 0, 1, "R8"); rd(12'h020, 2, 1, "R8");
      wr(12'h024, 1, 2, 1, "R10"); rd(12'h020, 2, 1, "R10");
      wr(12'h028, 0, 2, 1, "R10"); wr(12'h034, 1, 2, 1, "R10"); rd(12'h020, 2, 1, "R10");
      wr(12'h024, 1, 2, 1, "R10");

      // R11 capture of first blocked transfer
      wr(12'h018, 0, 2, 1, "R11"); wr(12'h01C, 32'h0000_0008, 2, 1, "R11");
      wr(12'h01C, 32'h0000_0020, 2, 1, "R11");
      blk(32'h0000_3000, 16'hBEEF, 1, "R11");
      rd(12'h02C, 2, 1, "R11"); rd(12'h030, 2, 1, "R11"); rd(12'h020, 2, 1, "R11");
      blk(32'h0000_5000, 16'h1111, 0, "R11");
      rd(12'h02C, 2, 1, "R11"); rd(12'h030, 2, 1, "R11");
      wr(12'h028, 1, 2, 1, "R11"); wr(12'h024, 1, 2, 1, "R11");
      blk(32'h0002_5000, 16'h00A5, 0, "R11"); rd(12'h030, 2, 1, "R11");
      wr(12'h024, 1, 2, 1, "R11");
      blk(32'h8000_0000, 16'h1234, 1, "R11");
      rd(12'h02C, 2, 1, "R11"); rd(12'h030, 2, 1, "R11"); rd(12'h031, 0, 1, "R11");
      wr(12'h024, 1, 2, 1, "R11");
      cyc(1, 1, 12'h024, 2, 1, 1, 1, 32'h0000_7000, 16'h7777, 1, "R11");
      rd(12'h020, 2, 1, "R11"); rd(12'h02C, 2, 1, "R11");

      // R12 read-only and unmapped
      wr(12'h010, 32'h55, 2, 1, "R12"); wr(12'h014, 32'h55, 2, 1, "R12");
      wr(12'h02C, 32'h55, 2, 1, "R12"); wr(12'h040, 32'h55, 2, 1, "R12");
      rd(12'h010, 2, 1, "R12"); rd(12'h014, 2, 1, "R12"); rd(12'h02C, 2, 1, "R12");
      rd(12'h024, 2, 1, "R12"); rd(12'h034, 2, 1, "R12"); rd(12'h040, 2, 1, "R12");

      // R6 lockdown
      wr(12'h018, 0, 2, 1, "R6");
      wr(12'h000, 32'h8000_0100, 2, 1, "R6"); rd(12'h000, 2, 1, "R6");
      wr(12'h000, 32'h0000_0010, 2, 1, "R6"); rd(12'h000, 2, 1, "R6");
      wr(12'h01C, 32'hFFFF_FFFF, 2, 1, "R6"); rd(12'h018, 2, 1, "R6");
      rd(12'h01C, 2, 1, "R6"); rd(12'h018, 2, 1, "R6");
      wr(12'h028, 1, 2, 1, "R6"); wr(12'h034, 1, 2, 1, "R6"); rd(12'h028, 2, 1, "R6");
      wr(12'h018, 3, 2, 1, "R6"); rd(12'h018, 2, 1, "R6");
      wr(12'h024, 1, 2, 1, "R6"); rd(12'h020, 2, 1, "R6");

      // R1 R6 reset releases lockdown
      do_reset();
      rd(12'h000, 2, 1, "R6"); rd(12'h01C, 2, 1, "R1");
      wr(12'h000, 32'h10, 2, 1, "R6"); rd(12'h000, 2, 1, "R6");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule